// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block is the command register of a flash-style memory. It watches host write cycles and recognizes multi-write command sequences. Each sequence opens with two fixed address/data unlock writes. From them the block issues one-cycle start pulses for a word program or a whole-array erase, and it tracks two mode levels: the identification readout mode and the secured-sector mode. Any write that does not fit the expected sequence sends the decoder back to plain array-read mode, and no operation starts.

In identification mode the block also drives the read data path. Instead of passing through the array word, it returns a manufacturer code, a device code or a secured-sector lock indicator, selected by the low read address. A logic-level accelerate flag lets a program command skip both unlock writes. While the embedded algorithm reports busy, every write is ignored.

Top module: `cmdseq_decoder`

## Requirements
- R1: After reset the decoder is in array-read mode: `id_mode`, `secure_mode`, `prog_start` and `erase_start` are 0 and `rd_data` equals `rd_array_data`.
- R2: The writes 0xAA to 0x555, 0x55 to 0x2AA and 0xA0 to 0x555 arm programming. The next write, whatever its data (0xF0 included), makes `prog_start` 1 for exactly the one cycle after that write is sampled. In that cycle `prog_addr` and `prog_data` carry that write's full address and data.
- R3: The six writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 make `erase_start` 1 for the one cycle after the last write.
- R4: While `accel` is 1 and the decoder is in array-read mode, a single 0xA0 write to 0x555 arms programming. While `accel` is 0 the same write has no effect.
- R5: A write whose address or data does not match the next expected cycle returns the decoder to array-read mode with no start pulse. That write is not taken as the first cycle of a new sequence.
- R6: The unlock writes followed by 0x90 to 0x555 set `id_mode`. While `id_mode` is 1, `rd_data` is 0x00C2 when the low 8 read-address bits are 0x00, 0x22FD when they are 0x01, the lock indicator when they are 0x03, and 0x0000 for any other value. While `id_mode` is 0, `rd_data` follows `rd_array_data`.
- R7: The lock indicator is 0x0088 when `lock_strap` is 1 and 0x0048 when it is 0.
- R8: In identification mode, a write with data byte 0xF0 to any address clears `id_mode`. When `secure_mode` is 1, a write with data byte 0x00 also clears it. Every other write leaves the decoder unchanged.
- R9: A 0xF0 write partway through an unlock or erase sequence returns the decoder to array-read mode, and `secure_mode` keeps its value.
- R10: The unlock writes followed by 0x88 to 0x555 set `secure_mode` and leave the decoder in array-read mode. To leave the secured sector, write the unlock pair, then 0x90 to 0x555, then data 0x00. This clears both `secure_mode` and `id_mode`.
- R11: While `busy` is 1, writes are ignored: no pulse, no mode change and no sequence progress.
- R12: Sequence matching compares only the low 11 address bits and the low 8 data bits. All higher bits are don't-care.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DW | Write data |
| accel | input | 1 | Accelerate flag, skips the unlock writes for programming |
| busy | input | 1 | Embedded operation in progress |
| lock_strap | input | 1 | Secured sector locked in manufacture |
| rd_addr | input | ADDR_W | Read address |
| rd_array_data | input | DW | Word read from the array |
| rd_data | output | DW | Read data, array word or identification code |
| prog_start | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program address, valid with `prog_start` |
| prog_data | output | DW | Program data, valid with `prog_start` |
| erase_start | output | 1 | One-cycle whole-array erase request |
| id_mode | output | 1 | Identification readout mode |
| secure_mode | output | 1 | Secured-sector mode |

## Verification
The start pulses, their address and data, and both mode levels are registered. They take their new value at the clock edge that samples the write and are due one cycle later. `rd_data` is combinational from `rd_addr` and the mode, so it is due in the same cycle. The bench drives each write on a falling edge and compares the registered results at the next falling edge, one full edge after sampling. It applies each read address and checks `rd_data` a fraction of a cycle later, inside the same low phase.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    typedef enum logic [2:0] {
        ST_READ     = 3'd0,
        ST_UNL1     = 3'd1,
        ST_UNL2     = 3'd2,
        ST_PGM_ARM  = 3'd3,
        ST_ERS_SET  = 3'd4,
        ST_ERS_UNL1 = 3'd5,
        ST_ERS_UNL2 = 3'd6,
        ST_IDMODE   = 3'd7
    } seq_state_e;

    // classified view of one host write
    typedef struct packed {
        logic key_a;    // 0xAA at first unlock address
        logic key_b;    // 0x55 at second unlock address
        logic pgm;      // 0xA0 at command address
        logic ers_set;  // 0x80 at command address
        logic ers_go;   // 0x10 at command address
        logic idm;      // 0x90 at command address
        logic sec;      // 0x88 at command address
        logic rst;      // 0xF0 anywhere
        logic zero;     // 0x00 anywhere
    } cmd_hits_t;

    localparam int          NCMD       = 7;
    localparam logic [7:0]  CMD_TBL [NCMD] = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h10, 8'h90, 8'h88};
    localparam int          IX_AA      = 0;
    localparam int          IX_55      = 1;
    localparam int          IX_A0      = 2;
    localparam int          IX_80      = 3;
    localparam int          IX_10      = 4;
    localparam int          IX_90      = 5;
    localparam int          IX_88      = 6;
    localparam logic [7:0]  RST_BYTE   = 8'hF0;
    localparam logic [7:0]  EXIT_BYTE  = 8'h00;
    localparam logic [11:0] ADR_CMD    = 12'h555;
    localparam logic [11:0] ADR_ALT    = 12'h2AA;

    localparam logic [15:0] CODE_MFR    = 16'h00C2;
    localparam logic [15:0] CODE_DEV    = 16'h22FD;
    localparam logic [15:0] CODE_LOCKED = 16'h0088;
    localparam logic [15:0] CODE_OPEN   = 16'h0048;

endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match
    import cmdseq_pkg::*;
#(
    parameter int CMP_AW = 11
) (
    input  logic [CMP_AW-1:0] addr_lo,
    input  logic [7:0]        data_lo,
    output cmd_hits_t         hits
);
    localparam logic [CMP_AW-1:0] A_CMD = CMP_AW'(ADR_CMD);
    localparam logic [CMP_AW-1:0] A_ALT = CMP_AW'(ADR_ALT);

    logic [NCMD-1:0] byte_hit;
    logic            at_cmd;
    logic            at_alt;

    for (genvar i = 0; i < NCMD; i++) begin : g_byte
        assign byte_hit[i] = (data_lo == CMD_TBL[i]);
    end

    assign at_cmd = (addr_lo == A_CMD);
    assign at_alt = (addr_lo == A_ALT);

    always_comb begin
        hits         = '0;
        hits.key_a   = at_cmd & byte_hit[IX_AA];
        hits.key_b   = at_alt & byte_hit[IX_55];
        hits.pgm     = at_cmd & byte_hit[IX_A0];
        hits.ers_set = at_cmd & byte_hit[IX_80];
        hits.ers_go  = at_cmd & byte_hit[IX_10];
        hits.idm     = at_cmd & byte_hit[IX_90];
        hits.sec     = at_cmd & byte_hit[IX_88];
        hits.rst     = (data_lo == RST_BYTE);
        hits.zero    = (data_lo == EXIT_BYTE);
    end
endmodule

// File: rtl/cmdseq_idrom.sv
module cmdseq_idrom
    import cmdseq_pkg::*;
#(
    parameter int DW       = 16,
    parameter int ID_SEL_W = 8
) (
    input  logic                id_mode,
    input  logic                lock_strap,
    input  logic [ID_SEL_W-1:0] sel,
    input  logic [DW-1:0]       array_data,
    output logic [DW-1:0]       rd_data
);
    localparam logic [ID_SEL_W-1:0] SEL_MFR  = ID_SEL_W'(0);
    localparam logic [ID_SEL_W-1:0] SEL_DEV  = ID_SEL_W'(1);
    localparam logic [ID_SEL_W-1:0] SEL_LOCK = ID_SEL_W'(3);

    logic [DW-1:0] id_word;

    always_comb begin
        if (sel == SEL_MFR)       id_word = DW'(CODE_MFR);
        else if (sel == SEL_DEV)  id_word = DW'(CODE_DEV);
        else if (sel == SEL_LOCK) id_word = lock_strap ? DW'(CODE_LOCKED) : DW'(CODE_OPEN);
        else                      id_word = '0;
        rd_data = id_mode ? id_word : array_data;
    end
endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DW       = 16,
    parameter int CMP_AW   = 11,
    parameter int ID_SEL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              accel,
    input  logic              busy,
    input  logic              lock_strap,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     rd_array_data,
    output logic [DW-1:0]     rd_data,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DW-1:0]     prog_data,
    output logic              erase_start,
    output logic              id_mode,
    output logic              secure_mode
);
    typedef struct packed {
        seq_state_e        st;
        logic              secure;
        logic              pgm_go;
        logic              ers_go;
        logic [ADDR_W-1:0] pa;
        logic [DW-1:0]     pd;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    cmd_hits_t hit;
    logic      take;

    cmdseq_match #(.CMP_AW(CMP_AW)) u_match (
        .addr_lo (wr_addr[CMP_AW-1:0]),
        .data_lo (wr_data[7:0]),
        .hits    (hit)
    );

    assign take = wr_en & ~busy;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.pgm_go = 1'b0;
        ctl_d.ers_go = 1'b0;
        if (take) begin
            unique case (ctl_q.st)
                ST_READ: begin
                    if (hit.key_a)            ctl_d.st = ST_UNL1;
                    else if (accel && hit.pgm) ctl_d.st = ST_PGM_ARM;
                end
                ST_UNL1: ctl_d.st = hit.key_b ? ST_UNL2 : ST_READ;
                ST_UNL2: begin
                    ctl_d.st = ST_READ;
                    if (hit.pgm)          ctl_d.st = ST_PGM_ARM;
                    else if (hit.ers_set) ctl_d.st = ST_ERS_SET;
                    else if (hit.idm)     ctl_d.st = ST_IDMODE;
                    else if (hit.sec)     ctl_d.secure = 1'b1;
                end
                ST_PGM_ARM: begin
                    ctl_d.pgm_go = 1'b1;
                    ctl_d.pa     = wr_addr;
                    ctl_d.pd     = wr_data;
                    ctl_d.st     = ST_READ;
                end
                ST_ERS_SET:  ctl_d.st = hit.key_a ? ST_ERS_UNL1 : ST_READ;
                ST_ERS_UNL1: ctl_d.st = hit.key_b ? ST_ERS_UNL2 : ST_READ;
                ST_ERS_UNL2: begin
                    ctl_d.ers_go = hit.ers_go;
                    ctl_d.st     = ST_READ;
                end
                ST_IDMODE: begin
                    if (hit.rst) begin
                        ctl_d.st = ST_READ;
                    end else if (ctl_q.secure && hit.zero) begin
                        ctl_d.st     = ST_READ;
                        ctl_d.secure = 1'b0;
                    end
                end
                default: ctl_d.st = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_READ, secure: 1'b0, pgm_go: 1'b0, ers_go: 1'b0, pa: '0, pd: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign prog_start  = ctl_q.pgm_go;
    assign prog_addr   = ctl_q.pa;
    assign prog_data   = ctl_q.pd;
    assign erase_start = ctl_q.ers_go;
    assign id_mode     = (ctl_q.st == ST_IDMODE);
    assign secure_mode = ctl_q.secure;

    cmdseq_idrom #(.DW(DW), .ID_SEL_W(ID_SEL_W)) u_idrom (
        .id_mode    (id_mode),
        .lock_strap (lock_strap),
        .sel        (rd_addr[ID_SEL_W-1:0]),
        .array_data (rd_array_data),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/cmdseq_decoder_chk.sv
module cmdseq_decoder_chk #(
    parameter int DW       = 16,
    parameter int ID_SEL_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [7:0]          wr_byte,
    input logic                busy,
    input logic                prog_start,
    input logic                erase_start,
    input logic                id_mode,
    input logic                secure_mode,
    input logic [ID_SEL_W-1:0] rd_sel,
    input logic [DW-1:0]       rd_data
);
    // R11
    busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!prog_start && !erase_start));

    // R11
    busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(id_mode) && $stable(secure_mode)));

    // R2
    prog_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    // R3
    erase_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> ($past(wr_en) && $past(wr_byte) == 8'h10));

    // R6
    id_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> ($past(wr_en) && $past(wr_byte) == 8'h90));

    // R8
    id_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_mode) |-> ($past(wr_en) && ($past(wr_byte) == 8'hF0 || $past(wr_byte) == 8'h00)));

    // R10
    secure_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(secure_mode) |-> ($past(wr_en) && $past(wr_byte) == 8'h88));

    // R6
    id_mfr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && rd_sel == '0) |-> (rd_data == DW'(16'h00C2)));
endmodule

bind cmdseq_decoder cmdseq_decoder_chk #(.DW(DW), .ID_SEL_W(ID_SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_byte     (wr_data[7:0]),
    .busy        (busy),
    .prog_start  (prog_start),
    .erase_start (erase_start),
    .id_mode     (id_mode),
    .secure_mode (secure_mode),
    .rd_sel      (rd_addr[ID_SEL_W-1:0]),
    .rd_data     (rd_data)
);

// File: tb/cmdseq_decoder_bench.sv
module cmdseq_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [20:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        accel = 1'b0;
    logic        busy = 1'b0;
    logic        lock_strap = 1'b1;
    logic [20:0] rd_addr = '0;
    logic [15:0] rd_array_data = 16'h5A5A;
    logic [15:0] rd_data;
    logic        prog_start;
    logic [20:0] prog_addr;
    logic [15:0] prog_data;
    logic        erase_start;
    logic        id_mode;
    logic        secure_mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // model state: 0 read,1 unl1,2 unl2,3 armed,4 ers-set,5 ers-unl1,6 ers-unl2,7 id
    int          m_st  = 0;
    bit          m_sec = 0;
    bit          e_pg, e_er;
    logic [20:0] e_pa;
    logic [15:0] e_pd;

    always #2 clk = ~clk;

    cmdseq_decoder u_cmdseq_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .accel(accel), .busy(busy), .lock_strap(lock_strap), .rd_addr(rd_addr),
        .rd_array_data(rd_array_data), .rd_data(rd_data), .prog_start(prog_start),
        .prog_addr(prog_addr), .prog_data(prog_data), .erase_start(erase_start),
        .id_mode(id_mode), .secure_mode(secure_mode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_id(input logic [20:0] a, input bit lk);
        case (a[7:0])
            8'h00:   return 16'h00C2;
            8'h01:   return 16'h22FD;
            8'h03:   return lk ? 16'h0088 : 16'h0048;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_apply(input logic [20:0] a, input logic [15:0] d);
        bit at5, at2;
        logic [7:0] b;
        e_pg = 0; e_er = 0;
        if (busy) return;
        b   = d[7:0];
        at5 = (a[10:0] == 11'h555);
        at2 = (a[10:0] == 11'h2AA);
        case (m_st)
            0: if (at5 && b == 8'hAA) m_st = 1;
               else if (accel && at5 && b == 8'hA0) m_st = 3;
            1: m_st = (at2 && b == 8'h55) ? 2 : 0;
            2: begin
                m_st = 0;
                if (at5 && b == 8'hA0) m_st = 3;
                else if (at5 && b == 8'h80) m_st = 4;
                else if (at5 && b == 8'h90) m_st = 7;
                else if (at5 && b == 8'h88) m_sec = 1;
            end
            3: begin e_pg = 1; e_pa = a; e_pd = d; m_st = 0; end
            4: m_st = (at5 && b == 8'hAA) ? 5 : 0;
            5: m_st = (at2 && b == 8'h55) ? 6 : 0;
            6: begin e_er = (at5 && b == 8'h10); m_st = 0; end
            default: begin
                if (b == 8'hF0) m_st = 0;
                else if (m_sec && b == 8'h00) begin m_st = 0; m_sec = 0; end
            end
        endcase
    endtask

    task automatic wr(input logic [20:0] a, input logic [15:0] d, input string req);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        model_apply(a, d);
        @(negedge clk);
        wr_en = 0;
        chk(prog_start == e_pg, req, "prog_start", 32'(prog_start), 32'(e_pg));
        chk(erase_start == e_er, req, "erase_start", 32'(erase_start), 32'(e_er));
        chk(id_mode == (m_st == 7), req, "id_mode", 32'(id_mode), 32'(m_st == 7));
        chk(secure_mode == m_sec, req, "secure_mode", 32'(secure_mode), 32'(m_sec));
        if (e_pg) begin
            chk(prog_addr == e_pa, req, "prog_addr", 32'(prog_addr), 32'(e_pa));
            chk(prog_data == e_pd, req, "prog_data", 32'(prog_data), 32'(e_pd));
        end
    endtask

    task automatic rd(input logic [20:0] a, input logic [15:0] arr, input string req);
        logic [15:0] exp;
        rd_addr = a; rd_array_data = arr;
        #1;
        exp = (m_st == 7) ? exp_id(a, lock_strap) : arr;
        chk(rd_data == exp, req, "rd_data", 32'(rd_data), 32'(exp));
    endtask

    task automatic unlock(input string req);
        wr(21'h00555, 16'h00AA, req);
        wr(21'h002AA, 16'h0055, req);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2417));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!id_mode, "R1", "id_mode", 32'(id_mode), 0);
        chk(!secure_mode, "R1", "secure_mode", 32'(secure_mode), 0);
        chk(!prog_start && !erase_start, "R1", "pulses", {prog_start, erase_start}, 0);
        rd(21'h00000, 16'h1357, "R1");

        // R2 program, data byte F0 still taken as program data
        unlock("R2");
        wr(21'h00555, 16'h00A0, "R2");
        wr(21'h1ABCD, 16'h00F0, "R2");
        @(negedge clk);
        chk(!prog_start, "R2", "pulse width", 32'(prog_start), 0);

        // R12 upper address and data bits ignored
        wr(21'h1F555, 16'h12AA, "R12");
        wr(21'h0A2AA, 16'hFF55, "R12");
        wr(21'h15555, 16'h77A0, "R12");
        wr(21'h00042, 16'hBEEF, "R12");

        // R3 erase
        unlock("R3");
        wr(21'h00555, 16'h0080, "R3");
        unlock("R3");
        wr(21'h00555, 16'h0010, "R3");

        // R5 wrong last erase byte, wrong address, repeated first cycle
        unlock("R5"); wr(21'h00555, 16'h0080, "R5"); unlock("R5");
        wr(21'h00555, 16'h0030, "R5");
        unlock("R5"); wr(21'h00554, 16'h00A0, "R5"); wr(21'h00100, 16'h1234, "R5");
        wr(21'h00555, 16'h00AA, "R5"); wr(21'h00555, 16'h00AA, "R5");
        wr(21'h002AA, 16'h0055, "R5"); wr(21'h00555, 16'h00A0, "R5");
        wr(21'h00200, 16'h4321, "R5");

        // R4 accelerate
        accel = 1;
        wr(21'h00555, 16'h00A0, "R4"); wr(21'h0FFFF, 16'hCAFE, "R4");
        accel = 0;
        wr(21'h00555, 16'h00A0, "R4"); wr(21'h0FFFF, 16'hCAFE, "R4");

        // R6 R7 identification readout
        unlock("R6"); wr(21'h00555, 16'h0090, "R6");
        rd(21'h00000, 16'h1111, "R6"); rd(21'h1FF01, 16'h1111, "R6");
        rd(21'h00005, 16'h1111, "R6");
        lock_strap = 1; rd(21'h00003, 16'h2222, "R7");
        lock_strap = 0; rd(21'h00003, 16'h2222, "R7");

        // R8 other writes ignored in id mode, 00 ignored when not secure
        wr(21'h00555, 16'h00AA, "R8"); wr(21'h00000, 16'h0000, "R8");
        rd(21'h00001, 16'h3333, "R8");
        // R11 busy ignores reset command
        busy = 1; wr(21'h00000, 16'h00F0, "R11"); busy = 0;
        wr(21'h12345, 16'h00F0, "R8");
        rd(21'h00001, 16'h3333, "R8");

        // R10 secured sector entry, R9 reset keeps it, exit sequence
        unlock("R10"); wr(21'h00555, 16'h0088, "R10");
        unlock("R9"); wr(21'h00555, 16'h0080, "R9"); wr(21'h00000, 16'h00F0, "R9");
        wr(21'h002AA, 16'h0055, "R9"); wr(21'h00555, 16'h0010, "R9");
        unlock("R10"); wr(21'h00555, 16'h0090, "R10"); wr(21'h00777, 16'h0000, "R10");

        // R11 program sequence under busy
        busy = 1;
        unlock("R11"); wr(21'h00555, 16'h00A0, "R11"); wr(21'h00010, 16'h9999, "R11");
        busy = 0;

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [20:0] a;
            logic [15:0] d;
            int c;
            c = $urandom_range(0, 9);
            a = 21'($urandom) & 21'h1FF800;
            d = 16'($urandom) & 16'hFF00;
            case (c)
                0: begin a[10:0] = 11'h555; d[7:0] = 8'hAA; end
                1: begin a[10:0] = 11'h2AA; d[7:0] = 8'h55; end
                2: begin a[10:0] = 11'h555; d[7:0] = 8'hA0; end
                3: begin a[10:0] = 11'h555; d[7:0] = 8'h80; end
                4: begin a[10:0] = 11'h555; d[7:0] = 8'h90; end
                5: begin a[10:0] = 11'h555; d[7:0] = 8'h88; end
                6: begin a[10:0] = 11'h555; d[7:0] = 8'h10; end
                7: begin a[10:0] = 11'($urandom); d[7:0] = 8'hF0; end
                8: begin a[10:0] = 11'($urandom); d[7:0] = 8'h00; end
                default: begin a = 21'($urandom); d = 16'($urandom); end
            endcase
            busy       = ($urandom_range(0, 7) == 0);
            accel      = ($urandom_range(0, 5) == 0);
            lock_strap = $urandom_range(0, 1);
            wr(a, d, "R2 R3 R5 R11 random");
            rd(21'($urandom_range(0, 4)), 16'($urandom), "R6 random");
        end
        busy = 0; accel = 0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule